// File: doc/BRIEF.md
# Reloading Down-Counter Timer with Square-Wave Output

This block is an 8-bit timer that counts down on a selectable tick. When the count passes below zero, the counter reloads from a programmable period value, emits a one-cycle interrupt pulse, and keeps counting without a pause. It picks its tick from one of three sources:
- the system clock divided by a power of two;
- a synchronized rising edge on an external clock pin;
- a synchronized rising edge of a slow sub-frequency clock, divided by the same prescaler.

In square-wave mode each reload also inverts an internal flip-flop. The pin carries the complement of that flip-flop. A period of P gives a 50% duty waveform whose half-period is P+1 ticks.

Software reaches the block through a small write port with four addresses:
- address 0 sets the period;
- address 1 sets run, mode, source and prescale;
- address 2 presets the flip-flop;
- address 3 clears the sticky interrupt flag.

Top module: `reload_tmr`

## Requirements
- R1: After reset the flip-flop is 0, so `tmr_pin` is 1. `irq_flag`, `irq_pulse` and `cnt_out` are 0, and the timer is stopped.
- R2: While running, the counter decrements by one per tick. A tick at count 0 reloads the period value, so underflows are P+1 ticks apart.
- R3: Every underflow gives a one-cycle `irq_pulse` in the cycle after the reloading edge, and counting continues from the reloaded value.
- R4: Control bit 1 = 1 selects square-wave mode. In that mode each underflow inverts the flip-flop, and `tmr_pin` always equals its inverse. With bit 1 = 0, `tmr_pin` does not change on underflow.
- R5: A write to address 2 loads `wr_data[0]` into the flip-flop. This write takes priority over a toggle in the same cycle.
- R6: The prescaler field, control bits 6:4 = s, divides the internal or sub-frequency events by 2^s. The value s ranges from 0 to 7.
- R7: Control bits 3:2 select the tick source: 0 is the prescaled system clock, 1 is the external pin, 2 is the prescaled sub-frequency clock, and 3 gives no ticks. Each external pin rising edge, after a two-flop synchronizer, gives exactly one tick.
- R8: A period write (address 0) while stopped (control bit 0 = 0) also loads the counter. While running, such a write leaves the counter alone until the next reload.
- R9: `irq_flag` sets on every underflow and stays set until a write to address 3 with `wr_data[0]` = 1. If both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| ext_clk_in | input | 1 | External count pin, asynchronous |
| sub_clk_in | input | 1 | Slow sub-frequency clock, asynchronous |
| tmr_pin | output | 1 | Inverted flip-flop output |
| irq_pulse | output | 1 | One-cycle underflow pulse |
| irq_flag | output | 1 | Sticky interrupt flag |
| cnt_out | output | 8 | Current counter value |

## Verification
The bench uses the default 8-bit width and 8-bit prescaler. Period 0 (an underflow every tick) and period 255 (the full 256-tick span) both fit in a short run. Prescale settings up to divide-by-8 are measured as exact pulse spacing, and the external and sub-frequency sources are driven slowly enough to count single edges.

// File: rtl/reload_tmr.sv
module reload_tmr #(
  parameter int W  = 8,
  parameter int PW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         ext_clk_in,
  input  logic         sub_clk_in,
  output logic         tmr_pin,
  output logic         irq_pulse,
  output logic         irq_flag,
  output logic [W-1:0] cnt_out
);
  localparam int SW = $clog2(PW + 1);

  logic [W-1:0]  period_q, cnt_q;
  logic          run_q, tog_q, ff_q;
  logic [1:0]    src_q;
  logic [SW-1:0] psel_q;
  logic [PW-1:0] pre_q, mask;
  logic [2:0]    ext_s, sub_s;
  logic          ext_rise, sub_rise, pre_ev, pre_hit, tick, uflow;

  wire wr_per = wr_en && wr_addr == 2'd0;
  wire wr_ctl = wr_en && wr_addr == 2'd1;
  wire wr_pre = wr_en && wr_addr == 2'd2;
  wire wr_clr = wr_en && wr_addr == 2'd3 && wr_data[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_s <= '0;
      sub_s <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_clk_in};
      sub_s <= {sub_s[1:0], sub_clk_in};
    end

  assign ext_rise = ext_s[1] & ~ext_s[2];
  assign sub_rise = sub_s[1] & ~sub_s[2];

  assign mask    = PW'((1 << psel_q) - 1);
  assign pre_ev  = (src_q == 2'd0) || (src_q == 2'd2 && sub_rise);
  assign pre_hit = pre_ev && ((pre_q & mask) == mask);

  always_comb
    case (src_q)
      2'd0, 2'd2: tick = pre_hit;
      2'd1:       tick = ext_rise;
      default:    tick = 1'b0;
    endcase

  assign uflow = run_q && tick && cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else if (!run_q) pre_q <= '0;
    else if (pre_ev) pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      period_q <= '0;
      run_q    <= 1'b0;
      tog_q    <= 1'b0;
      src_q    <= '0;
      psel_q   <= '0;
    end else begin
      if (wr_per) period_q <= wr_data;
      if (wr_ctl) begin
        run_q  <= wr_data[0];
        tog_q  <= wr_data[1];
        src_q  <= wr_data[3:2];
        psel_q <= SW'(wr_data[6:4]);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q     <= '0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= uflow;
      if (wr_per && !run_q)  cnt_q <= wr_data;
      else if (uflow)        cnt_q <= period_q;
      else if (run_q && tick) cnt_q <= cnt_q - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ff_q <= 1'b0;
    else if (wr_pre) ff_q <= wr_data[0];
    else if (uflow && tog_q) ff_q <= ~ff_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_flag <= 1'b0;
    else if (uflow) irq_flag <= 1'b1;
    else if (wr_clr) irq_flag <= 1'b0;

  assign tmr_pin = ~ff_q;
  assign cnt_out = cnt_q;

  a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> cnt_q == $past(period_q));
  a_r9_flag_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_flag);
  a_r4_pin_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && $past(tog_q) && !$past(wr_pre)) |-> tmr_pin != $past(tmr_pin));
  a_r4_pin_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tog_q) && !$past(wr_pre)) |-> $stable(tmr_pin));
  a_r8_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_q) && !$past(wr_per)) |-> $stable(cnt_q));
  a_r7_no_tick_src3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == 2'd3) |-> !tick);
endmodule

// File: tb/tb_reload_tmr.sv
module tb_reload_tmr;
  logic clk = 0, rst_n = 0, wr_en = 0, ext_clk_in = 0, sub_clk_in = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic tmr_pin, irq_pulse, irq_flag;
  logic [7:0] cnt_out;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  reload_tmr dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .ext_clk_in,
                  .sub_clk_in, .tmr_pin, .irq_pulse, .irq_flag, .cnt_out);

  // {period, prescale, square-wave mode}
  typedef struct packed { logic [7:0] per; logic [2:0] ps; logic tog; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'd3,   3'd0, 1'b0}, '{8'd0, 3'd0, 1'b1}, '{8'd7, 3'd2, 1'b1},
    '{8'd1,   3'd3, 1'b0}, '{8'd255, 3'd0, 1'b1}, '{8'd2, 3'd1, 1'b0}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_pulse(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk); #1; cyc++;
    end while (!irq_pulse && cyc < 5000);
    if (!irq_pulse) check(0, "R3 pulse timeout", cyc, 0);
  endtask

  task automatic pin_edge(ref logic p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); p = 1; repeat (4) @(negedge clk);
      p = 0; repeat (4) @(negedge clk);
    end
  endtask

  function automatic logic [7:0] ctl(logic run, logic tog, logic [1:0] src, logic [2:0] ps);
    return {1'b0, ps, src, tog, run};
  endfunction

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c, p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(tmr_pin == 1, "R1 pin", tmr_pin, 1);
    check(irq_flag == 0 && irq_pulse == 0, "R1 irq", irq_flag, 0);
    check(cnt_out == 0, "R1 cnt", cnt_out, 0);
    repeat (5) @(negedge clk);
    check(cnt_out == 0 && irq_flag == 0, "R1 stopped", cnt_out, 0);

    foreach (VECS[i]) begin
      wr(2'd1, 8'h00);
      wr(2'd3, 8'h01);
      wr(2'd2, 8'h00);
      wr(2'd0, VECS[i].per);
      check(cnt_out == VECS[i].per, "R8 load while stopped", cnt_out, VECS[i].per);
      wr(2'd1, ctl(1, VECS[i].tog, 2'd0, VECS[i].ps));
      wait_pulse(c);
      p0 = tmr_pin;
      check(irq_flag == 1, "R9 flag set", irq_flag, 1);
      check(p0 == (VECS[i].tog ? 0 : 1), "R4 pin after first underflow", p0, VECS[i].tog ? 0 : 1);
      wait_pulse(c);
      check(c == (VECS[i].per + 1) * (1 << VECS[i].ps), "R2 R6 interval", c,
            (VECS[i].per + 1) * (1 << VECS[i].ps));
      check((tmr_pin != p0) == VECS[i].tog, "R4 pin toggle", tmr_pin, VECS[i].tog ? !p0 : p0);
      if (VECS[i].per != 0 || VECS[i].ps != 0) begin
        @(posedge clk); #1;
        check(irq_pulse == 0, "R3 one-cycle pulse", irq_pulse, 0);
      end
    end

    // R9 clear and sticky
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h01);
    check(irq_flag == 0, "R9 cleared", irq_flag, 1'b0);
    wr(2'd3, 8'h00);
    check(irq_flag == 0, "R9 clear needs bit0", irq_flag, 0);

    // R5 preset
    wr(2'd2, 8'h01);
    check(tmr_pin == 0, "R5 preset one", tmr_pin, 0);
    wr(2'd2, 8'h00);
    check(tmr_pin == 1, "R5 preset zero", tmr_pin, 1);

    // R7 external pin source
    wr(2'd0, 8'd2);
    wr(2'd1, ctl(1, 1, 2'd1, 3'd5));
    repeat (20) @(negedge clk);
    check(cnt_out == 2, "R7 no edge no tick", cnt_out, 2);
    pin_edge(ext_clk_in, 1);
    check(cnt_out == 1, "R7 one edge one tick", cnt_out, 1);
    pin_edge(ext_clk_in, 1);
    check(cnt_out == 0 && irq_flag == 0, "R7 second edge", cnt_out, 0);
    pin_edge(ext_clk_in, 1);
    check(irq_flag == 1 && cnt_out == 2, "R7 third edge underflows", cnt_out, 2);
    check(tmr_pin == 0, "R4 toggled on ext", tmr_pin, 0);

    // R7 sub-frequency source with prescale 2
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'd1);
    wr(2'd1, ctl(1, 0, 2'd2, 3'd1));
    pin_edge(sub_clk_in, 3);
    check(irq_flag == 0 && cnt_out == 0, "R6 R7 sub three edges", cnt_out, 0);
    pin_edge(sub_clk_in, 1);
    check(irq_flag == 1 && cnt_out == 1, "R6 R7 sub four edges", cnt_out, 1);

    // R7 source 3 gives no ticks
    wr(2'd1, ctl(1, 0, 2'd3, 3'd0));
    repeat (30) @(negedge clk);
    check(cnt_out == 1, "R7 reserved source", cnt_out, 1);

    // R8 period write while running
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd5);
    wr(2'd1, ctl(1, 0, 2'd0, 3'd0));
    wr(2'd0, 8'd200);
    check(cnt_out <= 5, "R8 running write leaves count", cnt_out, 5);
    wait_pulse(c);
    check(cnt_out == 200, "R8 new period on reload", cnt_out, 200);
    wait_pulse(c);
    check(c == 201, "R2 new interval", c, 201);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule